// File: doc/BRIEF.md
# Windowed Register Index Flattener

This block turns an architectural integer register number into an index into one flat physical register array. That array holds every bank of global registers, every register window, and a small set of internal microcode registers. The mapping uses the current global-bank level and the current window pointer. Two extra alias ranges let a caller reach the windowed registers of the window before or after the current one. This gives save and restore style operations direct access to a neighbouring window without changing the pointer.

The computation is combinational. With the default configuration it is followed by one output register stage that is loaded on a valid-in strobe. The window count, the number of global banks and the number of microcode registers are parameters. The window count must be a power of two and at least two, so that the wrap around the windowed region is a bit mask. Register numbers past the last alias range are flagged as invalid, and the index is then zero.

Top module: `regidx_flatten`

## Requirements
- R1: Register numbers 0 to 7 map to `reg + glvl*8`, so each global level selects its own bank of eight.
- R2: Register numbers 8 to 31 map to `MAX_GLV*8 + ((reg - 8 - cwp*16) mod (NUM_WIN*16))`. With the defaults this is `32 + ((reg - 8 - cwp*16) mod 128)`.
- R3: Register numbers 32 to 32+NUM_UREG-1 are microcode registers. They map to `MAX_GLV*8 + NUM_WIN*16 + (reg - 32)`, which is 160 to 167 with the defaults.
- R4: The previous-window alias range starts at 32+NUM_UREG (40 to 71 with the defaults). Call the position within the range the offset. Offsets 0 to 7 map as in R1. Offsets 8 to 31 map as in R2, with the window pointer taken as cwp-1 modulo NUM_WIN, so that cwp=0 uses window NUM_WIN-1.
- R5: The next-window alias range starts at 64+NUM_UREG (72 to 103 with the defaults). Offsets 0 to 7 map as in R1. Offsets 8 to 31 map as in R2, with the window pointer taken as cwp+1 modulo NUM_WIN, so that cwp=NUM_WIN-1 uses window 0.
- R6: A register number at or above 96+NUM_UREG (104 with the defaults) drives `bad_idx` high and `flat_idx` to zero. Any valid number drives `bad_idx` low.
- R7: With the output stage enabled, `out_vld` equals the `in_vld` of the previous clock. The result shown with it belongs to the inputs presented on that same previous clock.
- R8: While reset is held, `out_vld`, `flat_idx` and `bad_idx` are all zero.
- R9: On a clock with `in_vld` low, `flat_idx` and `bad_idx` keep their previous values, whatever `reg_num`, `glvl` and `cwp` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Strobe: the lookup inputs on this cycle are valid |
| reg_num | input | $clog2(96+NUM_UREG+1) | Architectural register number (7 with the defaults) |
| glvl | input | $clog2(MAX_GLV) | Current global-bank level |
| cwp | input | $clog2(NUM_WIN) | Current window pointer |
| out_vld | output | 1 | The result is valid |
| flat_idx | output | $clog2(MAX_GLV*8+NUM_WIN*16+NUM_UREG) | Flat physical register index |
| bad_idx | output | 1 | The register number is beyond every legal range |

## Verification
The bench sweeps every register number up to the width limit, against every global level and window pointer. This covers the edges between the regions: 7/8, 31/32, 39/40, 47/48, 71/72, 79/80, 103/104. A design with a wrong boundary would send, for example, register 40 into the microcode block instead of global bank entry 0.

Wrapping the window pointer is the other key case. A design that forgot the wrap would compute cwp=0 in the previous alias, or cwp=7 in the next alias, into the global or microcode region instead of window 7 or window 0.

Cycles with a low strobe carry changing inputs. A design that loaded the output stage on every cycle would then show values that were never requested.

// File: rtl/regidx_flatten.sv
module regidx_flatten #(
  parameter int NUM_WIN  = 8,
  parameter int MAX_GLV  = 4,
  parameter int NUM_UREG = 8,
  parameter bit REG_OUT  = 1'b1,
  localparam int NUM_ARCH = 32,
  localparam int GLB_SZ   = MAX_GLV * 8,
  localparam int WIN_SZ   = NUM_WIN * 16,
  localparam int TOTAL    = GLB_SZ + WIN_SZ + NUM_UREG,
  localparam int IDX_W    = $clog2(TOTAL),
  localparam int LIMIT    = 3 * NUM_ARCH + NUM_UREG,
  localparam int RN_W     = $clog2(LIMIT + 1),
  localparam int GL_W     = (MAX_GLV > 1) ? $clog2(MAX_GLV) : 1,
  localparam int CW_W     = $clog2(NUM_WIN),
  localparam int WW       = CW_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [RN_W-1:0]  reg_num,
  input  logic [GL_W-1:0]  glvl,
  input  logic [CW_W-1:0]  cwp,
  output logic             out_vld,
  output logic [IDX_W-1:0] flat_idx,
  output logic             bad_idx
);

  logic [RN_W-1:0]  ofs;
  logic [1:0]       wsel;
  logic             micro, bad_c;
  logic [CW_W-1:0]  cadj;
  logic [WW-1:0]    wrel;
  logic [IDX_W-1:0] idx_c;

  always_comb begin
    ofs   = reg_num;
    wsel  = 2'd0;
    micro = 1'b0;
    bad_c = 1'b0;
    if (int'(reg_num) < NUM_ARCH) begin
      ofs = reg_num;
    end else if (int'(reg_num) < NUM_ARCH + NUM_UREG) begin
      micro = 1'b1;
    end else if (int'(reg_num) < 2 * NUM_ARCH + NUM_UREG) begin
      ofs  = RN_W'(int'(reg_num) - (NUM_ARCH + NUM_UREG));
      wsel = 2'd1;
    end else if (int'(reg_num) < LIMIT) begin
      ofs  = RN_W'(int'(reg_num) - (2 * NUM_ARCH + NUM_UREG));
      wsel = 2'd2;
    end else begin
      bad_c = 1'b1;
    end
  end

  assign cadj = (wsel == 2'd1) ? cwp - 1'b1 :
                (wsel == 2'd2) ? cwp + 1'b1 : cwp;

  assign wrel = WW'(ofs) - WW'(8) - {cadj, 4'h0};

  always_comb begin
    if (bad_c)
      idx_c = '0;
    else if (micro)
      idx_c = IDX_W'(GLB_SZ + WIN_SZ) + IDX_W'(int'(reg_num) - NUM_ARCH);
    else if (int'(ofs) < 8)
      idx_c = IDX_W'(ofs) + IDX_W'({glvl, 3'b000});
    else
      idx_c = IDX_W'(GLB_SZ) + IDX_W'(wrel);
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_vld  <= 1'b0;
          flat_idx <= '0;
          bad_idx  <= 1'b0;
        end else begin
          out_vld <= in_vld;
          if (in_vld) begin
            flat_idx <= idx_c;
            bad_idx  <= bad_c;
          end
        end
      end

      assert_vld_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
      assert_vld_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
      assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(flat_idx) && $stable(bad_idx)));
      assert_bad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_idx |-> (flat_idx == '0));
      assert_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !bad_idx) |-> (int'(flat_idx) < TOTAL));
      assert_bad_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (bad_idx == (int'($past(reg_num)) >= LIMIT)));
    end else begin : g_comb
      assign out_vld  = in_vld;
      assign flat_idx = idx_c;
      assign bad_idx  = bad_c;
    end
  endgenerate

endmodule

// File: tb/regidx_flatten_tb.sv
`timescale 1ns/1ps
module regidx_flatten_tb;
  localparam int NW = 8, MG = 4, NU = 8;
  localparam int NA = 32, WSZ = NW * 16;

  logic clk = 1'b0, rst_n = 1'b0, in_vld = 1'b0;
  logic [6:0] reg_num = '0;
  logic [1:0] glvl = '0;
  logic [2:0] cwp = '0;
  logic out_vld, bad_idx;
  logic [7:0] flat_idx;

  int n_chk = 0, n_bad = 0;
  int e_idx = 0, e_bad = 0, e_vld = 0;
  string e_tag = "R8";

  always #2.5 clk = ~clk;

  regidx_flatten #(.NUM_WIN(NW), .MAX_GLV(MG), .NUM_UREG(NU), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .reg_num(reg_num),
    .glvl(glvl), .cwp(cwp), .out_vld(out_vld), .flat_idx(flat_idx), .bad_idx(bad_idx));

  function automatic int win_map(int o, int c);
    return MG * 8 + ((o - 8 - c * 16 + 4 * WSZ) % WSZ);
  endfunction

  function automatic int model_idx(int r, int g, int c);
    int o;
    if (r < 8) return r + g * 8;
    if (r < NA) return win_map(r, c);
    if (r < NA + NU) return MG * 8 + WSZ + (r - NA);
    if (r < 2 * NA + NU) begin
      o = r - (NA + NU);
      return (o < 8) ? o + g * 8 : win_map(o, c - 1);
    end
    if (r < 3 * NA + NU) begin
      o = r - (2 * NA + NU);
      return (o < 8) ? o + g * 8 : win_map(o, c + 1);
    end
    return 0;
  endfunction

  function automatic string tag_of(int r);
    if (r < 8) return "R1";
    if (r < NA) return "R2";
    if (r < NA + NU) return "R3";
    if (r < 2 * NA + NU) return "R4";
    if (r < 3 * NA + NU) return "R5";
    return "R6";
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check("R7", int'(out_vld), e_vld, "out_vld");
    check(e_tag, int'(flat_idx), e_idx, "flat_idx");
    check(e_tag, int'(bad_idx), e_bad, "bad_idx");
  endtask

  task automatic step(bit v, int r, int g, int c);
    @(negedge clk);
    compare();
    in_vld  = v;
    reg_num = 7'(r);
    glvl    = 2'(g);
    cwp     = 3'(c);
    e_vld   = int'(v);
    if (v) begin
      e_idx = model_idx(r, g, c);
      e_bad = (r >= 3 * NA + NU) ? 1 : 0;
      e_tag = tag_of(r);
    end else begin
      e_tag = "R9";
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    in_vld = 1'b1; reg_num = 7'd50; glvl = 2'd3; cwp = 3'd5;
    repeat (3) @(negedge clk);
    e_tag = "R8";
    compare();
    in_vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int g = 0; g < MG; g++)
      for (int c = 0; c < NW; c++)
        for (int r = 0; r < 128; r++)
          step(((r + c + g) % 5) != 0, r, g, c);
    step(1'b1, 40, 0, 0);
    step(1'b0, 103, 3, 7);
    step(1'b1, 79, 0, 7);
    step(1'b1, 104, 1, 2);
    step(1'b0, 8, 2, 3);
    step(1'b0, 0, 0, 0);
    @(negedge clk);
    compare();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule